// File: doc/BRIEF.md
# Four-Cache Snooping MSI Coherence System

This block holds four small direct-mapped caches on one shared bus, together with a round-robin bus arbiter and a word-addressed main-memory model. A write-invalidate protocol with three line states (Invalid, Shared, Modified) keeps the caches coherent. Each cache serves a processor port with a valid/ready handshake. A load to a line held Shared or Modified completes without the bus, and so does a store to a line held Modified. Any other access holds the processor until the cache has won the bus and its transaction has finished. Completion is marked by a one-cycle done pulse, with load data alongside it.

Four transaction kinds travel on the bus:
- a read, which fetches a line to share;
- a read-for-ownership, issued on a store miss;
- an upgrade, which carries no data and is used for a store that finds its line Shared;
- a writeback, issued when a Modified victim is evicted.

Every other cache snoops each transaction. A cache that owns the line Modified provides the data in place of memory. On a remote read, memory captures the owner's data in that same transaction. Each transaction takes a single bus cycle, and the arbiter grants one per cycle, so all writes to a given address are serialized.

Line states are visible on an observation port so that coherence can be checked from outside. The bus activity and a memory probe port are visible in the same way.

Top module: `msi_snoop_system`

## Requirements
- R1: After reset every line of every cache reads state code 0 (Invalid), every cpu_ready is high, and memory word a holds (a*291 + 2989) mod 2^16. State codes on line_state are 0 Invalid, 1 Shared, 2 Modified, and cache c set s sits at bits (c*SETS+s)*2 +: 2.
- R2: A load miss with no Modified holder issues one read transaction (bus_kind 0). The line is filled from memory and installed as Shared, and the memory word is returned on cpu_rdata.
- R3: A cache that snoops a read for a line it holds Shared, or does not hold, keeps its line state unchanged.
- R4: A store to a Shared line issues one upgrade transaction (bus_kind 2) and no memory change. Every other Shared copy becomes Invalid, and the requester becomes Modified.
- R5: A store miss issues one read-for-ownership transaction (bus_kind 1). Any Modified holder goes Invalid, and the requester becomes Modified holding the stored word.
- R6: A read that meets a remote Modified owner gets the owner's data. The owner drops to Shared and memory takes the same data in that transaction.
- R7: A load to a Shared or Modified line, and a store to a Modified line, finish with a done pulse and no bus transaction.
- R8: At most one cache is granted per cycle, and only a requesting one. When several caches wait, grants go in rotating order starting after the last granted cache (bus_owner).
- R9: Replacing a Modified line first issues a writeback (bus_kind 3) that stores the old word to memory, then the fetch. Replacing a Shared line issues no writeback.
- R10: A request is accepted when cpu_valid and cpu_ready are both high. A bus-bound request drops cpu_ready until cpu_done pulses for one cycle after its final transaction.
- R11: No address is ever held Modified by more than one cache, and at most one cache supplies data in any transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | NC | Per-processor request valid |
| cpu_we | input | NC | Per-processor store (1) or load (0) |
| cpu_addr | input | NC*AW | Per-processor word address |
| cpu_wdata | input | NC*DW | Per-processor store data |
| cpu_ready | output | NC | Cache can accept a request |
| cpu_done | output | NC | One-cycle completion pulse |
| cpu_rdata | output | NC*DW | Load data, valid with cpu_done |
| line_state | output | NC*SETS*2 | State code of every line |
| bus_busy | output | 1 | A transaction occupies the bus this cycle |
| bus_kind | output | 2 | Transaction kind: 0 read, 1 read-for-ownership, 2 upgrade, 3 writeback |
| bus_owner | output | $clog2(NC) | Index of the granted cache |
| mem_probe_addr | input | AW | Memory observation address |
| mem_probe_data | output | DW | Memory word at mem_probe_addr |

## Verification
The bench builds the block with four caches of four sets each, a 6-bit address and 16-bit words. This gives a 64-word memory in which every set index is shared by 16 addresses. Random accesses are drawn from a 16-word window. That makes remote owners, upgrades racing against silent sharers, and evictions of Modified victims occur often, alongside the directed six-step sharing sequence and a four-way simultaneous request that exercises the rotating grant.

// File: rtl/msi_pkg.sv
package msi_pkg;

    typedef enum logic [1:0] {
        LS_I = 2'd0,
        LS_S = 2'd1,
        LS_M = 2'd2
    } line_st_t;

    typedef enum logic [1:0] {
        BOP_RD  = 2'd0,
        BOP_RDX = 2'd1,
        BOP_UPG = 2'd2,
        BOP_WB  = 2'd3
    } bus_op_t;

    function automatic int unsigned mem_seed(input int unsigned a);
        return a * 291 + 2989;
    endfunction

    function automatic logic op_fetches(input bus_op_t op);
        return (op == BOP_RD) || (op == BOP_RDX);
    endfunction

endpackage

// File: rtl/msi_rr_arbiter.sv
module msi_rr_arbiter #(
    parameter int NC = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NC-1:0]         req,
    output logic [NC-1:0]         gnt,
    output logic [$clog2(NC)-1:0] gidx,
    output logic                  any
);
    localparam int SW = $clog2(NC);

    logic [SW-1:0] last;

    always_comb begin
        gnt  = '0;
        gidx = '0;
        any  = 1'b0;
        for (int k = 1; k <= NC; k++) begin
            int cand;
            cand = (int'(last) + k) % NC;
            if (!any && req[cand]) begin
                any       = 1'b1;
                gnt[cand] = 1'b1;
                gidx      = SW'(cand);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last <= SW'(NC - 1);
        end else if (any) begin
            last <= gidx;
        end
    end

    // R8
    gnt_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt));

    // R8
    gnt_req_chk: assert property (@(posedge clk) disable iff (rst)
        (gnt & ~req) == '0);

endmodule

// File: rtl/msi_mem_model.sv
module msi_mem_model #(
    parameter int AW = 6,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] probe_addr,
    output logic [DW-1:0] probe_data
);
    import msi_pkg::*;

    localparam int WORDS = 1 << AW;

    logic [DW-1:0] mem [WORDS];

    assign rd_data    = mem[rd_addr];
    assign probe_data = mem[probe_addr];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int a = 0; a < WORDS; a++) begin
                mem[a] <= DW'(mem_seed(a));
            end
        end else if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

endmodule

// File: rtl/msi_cache.sv
module msi_cache #(
    parameter int ID   = 0,
    parameter int NC   = 4,
    parameter int SETS = 4,
    parameter int AW   = 6,
    parameter int DW   = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cpu_valid,
    input  logic                    cpu_we,
    input  logic [AW-1:0]           cpu_addr,
    input  logic [DW-1:0]           cpu_wdata,
    output logic                    cpu_ready,
    output logic                    cpu_done,
    output logic [DW-1:0]           cpu_rdata,
    output logic                    bus_req,
    input  logic                    bus_gnt,
    output msi_pkg::bus_op_t        my_op,
    output logic [AW-1:0]           my_addr,
    output logic [DW-1:0]           my_data,
    input  logic                    bus_valid,
    input  msi_pkg::bus_op_t        bus_op,
    input  logic [$clog2(NC)-1:0]   bus_src,
    input  logic [AW-1:0]           bus_addr,
    input  logic [DW-1:0]           fill_data,
    output logic                    snp_supply,
    output logic [DW-1:0]           snp_data,
    output logic [SETS*2-1:0]       line_state
);
    import msi_pkg::*;

    localparam int SW = $clog2(NC);
    localparam int IW = $clog2(SETS);
    localparam int TW = AW - IW;

    typedef enum logic {C_IDLE, C_REQ} cst_t;

    typedef struct packed {
        logic          we;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
    } preq_t;

    line_st_t      lst  [SETS];
    logic [TW-1:0] ltag [SETS];
    logic [DW-1:0] ldat [SETS];
    cst_t          st;
    preq_t         pend;

    logic [IW-1:0] c_idx, b_idx, p_idx;
    logic [TW-1:0] c_tag, b_tag, p_tag;
    logic          c_match, c_hit;
    logic          b_foreign, b_match, conflict;
    logic          p_match;

    assign c_idx = cpu_addr[IW-1:0];
    assign c_tag = cpu_addr[AW-1:IW];
    assign b_idx = bus_addr[IW-1:0];
    assign b_tag = bus_addr[AW-1:IW];
    assign p_idx = pend.addr[IW-1:0];
    assign p_tag = pend.addr[AW-1:IW];

    assign c_match   = (lst[c_idx] != LS_I) && (ltag[c_idx] == c_tag);
    assign c_hit     = c_match && (!cpu_we || lst[c_idx] == LS_M);
    assign b_foreign = bus_valid && (bus_src != SW'(ID));
    assign b_match   = b_foreign && (lst[b_idx] != LS_I) && (ltag[b_idx] == b_tag);
    assign conflict  = b_foreign && (b_idx == c_idx);
    assign p_match   = (lst[p_idx] != LS_I) && (ltag[p_idx] == p_tag);

    assign cpu_ready  = (st == C_IDLE) && !conflict;
    assign bus_req    = (st == C_REQ);
    assign snp_supply = b_match && (lst[b_idx] == LS_M) && op_fetches(bus_op);
    assign snp_data   = ldat[b_idx];

    always_comb begin
        if (p_match && lst[p_idx] == LS_S && pend.we) begin
            my_op = BOP_UPG;
        end else if (!p_match && lst[p_idx] == LS_M) begin
            my_op = BOP_WB;
        end else if (pend.we) begin
            my_op = BOP_RDX;
        end else begin
            my_op = BOP_RD;
        end
    end

    assign my_addr = (my_op == BOP_WB) ? {ltag[p_idx], p_idx} : pend.addr;
    assign my_data = (my_op == BOP_WB) ? ldat[p_idx] : pend.wdata;

    for (genvar s = 0; s < SETS; s++) begin : g_state
        assign line_state[s*2 +: 2] = lst[s];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= C_IDLE;
            pend      <= '0;
            cpu_done  <= 1'b0;
            cpu_rdata <= '0;
            for (int s = 0; s < SETS; s++) begin
                lst[s]  <= LS_I;
                ltag[s] <= '0;
                ldat[s] <= '0;
            end
        end else begin
            cpu_done <= 1'b0;
            if (b_match) begin
                case (bus_op)
                    BOP_RD:  if (lst[b_idx] == LS_M) lst[b_idx] <= LS_S;
                    BOP_RDX: lst[b_idx] <= LS_I;
                    BOP_UPG: lst[b_idx] <= LS_I;
                    default: ;
                endcase
            end
            case (st)
                C_IDLE: begin
                    if (cpu_valid && cpu_ready) begin
                        if (c_hit) begin
                            cpu_done <= 1'b1;
                            if (cpu_we) ldat[c_idx] <= cpu_wdata;
                            else        cpu_rdata   <= ldat[c_idx];
                        end else begin
                            pend <= '{we: cpu_we, addr: cpu_addr, wdata: cpu_wdata};
                            st   <= C_REQ;
                        end
                    end
                end
                C_REQ: begin
                    if (bus_gnt) begin
                        case (my_op)
                            BOP_WB: begin
                                lst[p_idx] <= LS_I;
                            end
                            BOP_UPG: begin
                                lst[p_idx]  <= LS_M;
                                ldat[p_idx] <= pend.wdata;
                                cpu_done    <= 1'b1;
                                st          <= C_IDLE;
                            end
                            BOP_RD: begin
                                lst[p_idx]  <= LS_S;
                                ltag[p_idx] <= p_tag;
                                ldat[p_idx] <= fill_data;
                                cpu_rdata   <= fill_data;
                                cpu_done    <= 1'b1;
                                st          <= C_IDLE;
                            end
                            default: begin
                                lst[p_idx]  <= LS_M;
                                ltag[p_idx] <= p_tag;
                                ldat[p_idx] <= pend.wdata;
                                cpu_done    <= 1'b1;
                                st          <= C_IDLE;
                            end
                        endcase
                    end
                end
                default: st <= C_IDLE;
            endcase
        end
    end

    // R4
    upg_to_m_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_gnt && my_op == BOP_UPG) |=> (lst[$past(p_idx)] == LS_M));

    // R6
    owner_down_chk: assert property (@(posedge clk) disable iff (rst)
        (snp_supply && bus_op == BOP_RD) |=> (lst[$past(b_idx)] == LS_S));

    // R3
    shared_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (b_match && bus_op == BOP_RD && lst[b_idx] == LS_S) |=> (lst[$past(b_idx)] == LS_S));

    // R10
    grant_done_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_gnt && my_op != BOP_WB) |=> cpu_done);

endmodule

// File: rtl/msi_snoop_system.sv
module msi_snoop_system #(
    parameter int NC   = 4,
    parameter int SETS = 4,
    parameter int AW   = 6,
    parameter int DW   = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NC-1:0]           cpu_valid,
    input  logic [NC-1:0]           cpu_we,
    input  logic [NC*AW-1:0]        cpu_addr,
    input  logic [NC*DW-1:0]        cpu_wdata,
    output logic [NC-1:0]           cpu_ready,
    output logic [NC-1:0]           cpu_done,
    output logic [NC*DW-1:0]        cpu_rdata,
    output logic [NC*SETS*2-1:0]    line_state,
    output logic                    bus_busy,
    output logic [1:0]              bus_kind,
    output logic [$clog2(NC)-1:0]   bus_owner,
    input  logic [AW-1:0]           mem_probe_addr,
    output logic [DW-1:0]           mem_probe_data
);
    import msi_pkg::*;

    localparam int SW = $clog2(NC);

    logic [NC-1:0] req, gnt, sup;
    bus_op_t       c_op   [NC];
    logic [AW-1:0] c_addr [NC];
    logic [DW-1:0] c_data [NC];
    logic [DW-1:0] c_sdat [NC];
    logic [SW-1:0] gidx;
    logic          any;

    bus_op_t       b_op;
    logic [AW-1:0] b_addr;
    logic [DW-1:0] b_data, sup_data, mem_rd, fill;
    logic          mem_we;
    logic [DW-1:0] mem_wd;

    msi_rr_arbiter #(.NC(NC)) u_arb (
        .clk (clk), .rst (rst), .req (req), .gnt (gnt), .gidx (gidx), .any (any)
    );

    for (genvar i = 0; i < NC; i++) begin : g_cache
        msi_cache #(.ID(i), .NC(NC), .SETS(SETS), .AW(AW), .DW(DW)) u_cache (
            .clk        (clk),
            .rst        (rst),
            .cpu_valid  (cpu_valid[i]),
            .cpu_we     (cpu_we[i]),
            .cpu_addr   (cpu_addr[i*AW +: AW]),
            .cpu_wdata  (cpu_wdata[i*DW +: DW]),
            .cpu_ready  (cpu_ready[i]),
            .cpu_done   (cpu_done[i]),
            .cpu_rdata  (cpu_rdata[i*DW +: DW]),
            .bus_req    (req[i]),
            .bus_gnt    (gnt[i]),
            .my_op      (c_op[i]),
            .my_addr    (c_addr[i]),
            .my_data    (c_data[i]),
            .bus_valid  (any),
            .bus_op     (b_op),
            .bus_src    (gidx),
            .bus_addr   (b_addr),
            .fill_data  (fill),
            .snp_supply (sup[i]),
            .snp_data   (c_sdat[i]),
            .line_state (line_state[i*SETS*2 +: SETS*2])
        );
    end

    assign b_op   = c_op[gidx];
    assign b_addr = c_addr[gidx];
    assign b_data = c_data[gidx];

    always_comb begin
        sup_data = '0;
        for (int i = 0; i < NC; i++) begin
            if (sup[i]) sup_data = sup_data | c_sdat[i];
        end
    end

    assign fill   = (|sup) ? sup_data : mem_rd;
    assign mem_we = any && ((b_op == BOP_WB) || (b_op == BOP_RD && |sup));
    assign mem_wd = (b_op == BOP_WB) ? b_data : sup_data;

    msi_mem_model #(.AW(AW), .DW(DW)) u_mem (
        .clk        (clk),
        .rst        (rst),
        .rd_addr    (b_addr),
        .rd_data    (mem_rd),
        .wr_en      (mem_we),
        .wr_addr    (b_addr),
        .wr_data    (mem_wd),
        .probe_addr (mem_probe_addr),
        .probe_data (mem_probe_data)
    );

    assign bus_busy  = any;
    assign bus_kind  = b_op;
    assign bus_owner = gidx;

    // R11
    single_supplier_chk: assert property (@(posedge clk) disable iff (rst)
        any |-> $onehot0(sup));

endmodule

// File: tb/msi_snoop_system_bench.sv
module msi_snoop_system_bench;
    localparam int NC = 4, SETS = 4, AW = 6, DW = 16, WORDS = 64;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic [NC-1:0]        cpu_valid = '0, cpu_we = '0;
    logic [NC*AW-1:0]     cpu_addr = '0;
    logic [NC*DW-1:0]     cpu_wdata = '0;
    logic [NC-1:0]        cpu_ready, cpu_done;
    logic [NC*DW-1:0]     cpu_rdata;
    logic [NC*SETS*2-1:0] line_state;
    logic                 bus_busy;
    logic [1:0]           bus_kind;
    logic [1:0]           bus_owner;
    logic [AW-1:0]        mem_probe_addr = '0;
    logic [DW-1:0]        mem_probe_data;

    msi_snoop_system #(.NC(NC), .SETS(SETS), .AW(AW), .DW(DW)) u_msi_snoop_system (
        .clk(clk), .rst(rst), .cpu_valid(cpu_valid), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
        .cpu_done(cpu_done), .cpu_rdata(cpu_rdata), .line_state(line_state),
        .bus_busy(bus_busy), .bus_kind(bus_kind), .bus_owner(bus_owner),
        .mem_probe_addr(mem_probe_addr), .mem_probe_data(mem_probe_data)
    );

    int errors = 0;
    int checks = 0;
    int mst [NC][SETS];
    int mtag[NC][SETS];
    int mdat[NC][SETS];
    int mmem[WORDS];
    int last_kind;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int init_word(input int a);
        return (a * 291 + 2989) & 16'hFFFF;
    endfunction

    task automatic model_reset();
        for (int c = 0; c < NC; c++)
            for (int s = 0; s < SETS; s++) begin
                mst[c][s] = 0; mtag[c][s] = 0; mdat[c][s] = 0;
            end
        for (int a = 0; a < WORDS; a++) mmem[a] = init_word(a);
    endtask

    // Reference model: 0 Invalid, 1 Shared, 2 Modified
    task automatic model_op(input int c, input bit we, input int a, input int d,
                            output int rd, output int nbus);
        int idx, tg, owner;
        bit hit;
        idx = a % SETS; tg = a / SETS; nbus = 0; rd = 0;
        hit = (mst[c][idx] != 0) && (mtag[c][idx] == tg);
        if (!we && hit) begin
            rd = mdat[c][idx];
        end else if (we && hit && mst[c][idx] == 2) begin
            mdat[c][idx] = d;
        end else if (we && hit) begin
            for (int o = 0; o < NC; o++)
                if (o != c && mst[o][idx] != 0 && mtag[o][idx] == tg) mst[o][idx] = 0;
            mst[c][idx] = 2; mdat[c][idx] = d; nbus = 1;
        end else begin
            if (mst[c][idx] == 2) begin
                mmem[mtag[c][idx] * SETS + idx] = mdat[c][idx];
                nbus++;
            end
            mst[c][idx] = 0;
            owner = -1;
            for (int o = 0; o < NC; o++)
                if (o != c && mst[o][idx] == 2 && mtag[o][idx] == tg) owner = o;
            if (!we) begin
                if (owner >= 0) begin
                    mmem[a] = mdat[owner][idx];
                    mst[owner][idx] = 1;
                    rd = mdat[owner][idx];
                end else begin
                    rd = mmem[a];
                end
                mst[c][idx] = 1; mtag[c][idx] = tg; mdat[c][idx] = rd;
            end else begin
                for (int o = 0; o < NC; o++)
                    if (o != c && mst[o][idx] != 0 && mtag[o][idx] == tg) mst[o][idx] = 0;
                mst[c][idx] = 2; mtag[c][idx] = tg; mdat[c][idx] = d;
            end
            nbus++;
        end
    endtask

    task automatic check_states(input string req);
        int nm;
        for (int c = 0; c < NC; c++)
            for (int s = 0; s < SETS; s++)
                chk(int'(line_state[(c*SETS+s)*2 +: 2]) == mst[c][s], req,
                    $sformatf("state c%0d s%0d", c, s),
                    int'(line_state[(c*SETS+s)*2 +: 2]), mst[c][s]);
        nm = 0;
        for (int c = 0; c < NC; c++)
            for (int o = c + 1; o < NC; o++)
                for (int s = 0; s < SETS; s++)
                    if (line_state[(c*SETS+s)*2 +: 2] == 2'd2 &&
                        line_state[(o*SETS+s)*2 +: 2] == 2'd2 && mtag[c][s] == mtag[o][s])
                        nm++;
        chk(nm == 0, "R11", "duplicate Modified owners", nm, 0);
    endtask

    task automatic probe(input int a, input string req);
        mem_probe_addr = AW'(a);
        #1;
        chk(int'(mem_probe_data) == mmem[a], req, $sformatf("memory word %0d", a),
            int'(mem_probe_data), mmem[a]);
    endtask

    task automatic run_op(input int c, input bit we, input int a, input int d,
                          input string req, input int kind_exp);
        int erd, enb, cnt, ncyc;
        model_op(c, we, a, d, erd, enb);
        @(negedge clk);
        while (!cpu_ready[c]) @(negedge clk);
        cpu_valid[c] = 1'b1; cpu_we[c] = we;
        cpu_addr[c*AW +: AW] = AW'(a); cpu_wdata[c*DW +: DW] = DW'(d);
        cnt = 0; ncyc = 0; last_kind = -1;
        do begin
            @(negedge clk);
            cpu_valid[c] = 1'b0;
            if (bus_busy) begin cnt++; last_kind = int'(bus_kind); end
            ncyc++;
        end while (!cpu_done[c] && ncyc < 40);
        chk(cpu_done[c], "R10", "done pulse", int'(cpu_done[c]), 1);
        chk(cnt == enb, req, "bus transactions", cnt, enb);
        if (kind_exp >= 0) chk(last_kind == kind_exp, req, "bus kind", last_kind, kind_exp);
        if (!we) chk(int'(cpu_rdata[c*DW +: DW]) == erd, req, "load data",
                     int'(cpu_rdata[c*DW +: DW]), erd);
        @(negedge clk);
        chk(cpu_done[c] == 1'b0, "R10", "done single cycle", int'(cpu_done[c]), 0);
        check_states(req);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        cpu_valid = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        int order[8];
        int cnt, guard, erd, enb;
        logic [NC-1:0] seen;
        void'($urandom(32'd2024));

        // R1 reset state
        do_reset();
        check_states("R1");
        chk(cpu_ready == 4'hF, "R1", "ready after reset", int'(cpu_ready), 15);
        probe(0, "R1"); probe(5, "R1"); probe(63, "R1");

        // R8 rotating arbitration: one miss by cache 2, then all four together
        run_op(2, 1'b0, 7, 0, "R2", 0);
        @(negedge clk);
        for (int c = 0; c < NC; c++) begin
            cpu_valid[c] = 1'b1; cpu_we[c] = 1'b0;
            cpu_addr[c*AW +: AW] = AW'(40 + c);
        end
        cnt = 0; guard = 0; seen = '0;
        do begin
            @(negedge clk);
            cpu_valid = '0;
            if (bus_busy && cnt < 8) begin order[cnt] = int'(bus_owner); cnt++; end
            seen = seen | cpu_done;
            guard++;
        end while (seen != 4'hF && guard < 40);
        chk(cnt == 4, "R8", "grant count", cnt, 4);
        for (int k = 0; k < 4; k++) begin
            chk(order[k] == (3 + k) % 4, "R8", $sformatf("grant %0d owner", k),
                order[k], (3 + k) % 4);
            model_op((3 + k) % 4, 1'b0, 40 + (3 + k) % 4, 0, erd, enb);
        end
        for (int c = 0; c < NC; c++)
            chk(int'(cpu_rdata[c*DW +: DW]) == init_word(40 + c), "R2", "parallel load data",
                int'(cpu_rdata[c*DW +: DW]), init_word(40 + c));
        check_states("R8");

        // Directed sharing sequence on address 5
        do_reset();
        run_op(0, 1'b0, 5, 0, "R2", 0);
        run_op(1, 1'b0, 5, 0, "R3", 0);
        run_op(1, 1'b1, 5, 16'h1111, "R4", 2);
        probe(5, "R4");
        run_op(2, 1'b1, 5, 16'h2222, "R5", 1);
        run_op(2, 1'b0, 5, 0, "R7", -1);
        run_op(2, 1'b1, 5, 16'h2233, "R7", -1);
        run_op(3, 1'b0, 5, 0, "R6", 0);
        probe(5, "R6");
        chk(int'(mem_probe_data) == 16'h2233, "R6", "memory holds owner data",
            int'(mem_probe_data), 16'h2233);
        run_op(3, 1'b0, 5, 0, "R7", -1);
        // R9: Shared victim is silent, Modified victim writes back
        run_op(3, 1'b1, 9, 16'h3333, "R9", 1);
        run_op(3, 1'b1, 5, 16'h4444, "R9", 1);
        probe(9, "R9");
        chk(int'(mem_probe_data) == 16'h3333, "R9", "writeback data",
            int'(mem_probe_data), 16'h3333);

        // Random traffic over a 16-word window
        for (int n = 0; n < 400; n++) begin
            int c, a, d;
            bit we;
            c  = int'($urandom % NC);
            we = 1'($urandom % 2);
            a  = int'($urandom % 16);
            d  = int'($urandom & 16'hFFFF);
            run_op(c, we, a, d, "R5", -1);
        end
        for (int a = 0; a < WORDS; a++) probe(a, "R9");

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule